// File: doc/BRIEF.md
# Breathing Duty Ramp Sequencer

This block produces the compare value for one PWM channel so that an LED driven by that channel fades up and down on its own, with no host writes. A tick divider counts a programmable number of clock cycles; on every tick a signed phase accumulator moves forward by a fixed step, and the new duty value is the magnitude of that accumulator. As the accumulator climbs from a large negative value through zero to a large positive one, the duty value first falls and then rises again, giving the breathing ramp.

Once the accumulator passes its upper bound it jumps back to its lower bound. That tick publishes nothing, so the duty output keeps its last value for one extra tick interval. Besides the duty value and its one-cycle update strobe, the block drives a fixed period word and a counter-enable flag to a separate PWM counter/comparator. The enable flag rises before the first duty value is published.

Top module: `breath_duty_seq`

## Requirements
- R1: While reset is low, `dutyOut` is 0, `dutyStrobe` is 0 and `countEnable` is 0. After reset is released the accumulator starts at -65535.
- R2: A tick happens on every TICK_CYCLES-th rising edge at which `runEn` is high, counted from reset release. On the edge of each non-wrap tick, `dutyStrobe` goes high for exactly one cycle, and the new duty value appears on `dutyOut` in that same cycle.
- R3: Each tick adds 10 to the accumulator. The published duty is the accumulator when it is positive and its negation otherwise. With the defaults, the first tick gives 65525 and the second gives 65515.
- R4: When the accumulator lands exactly on 0, the published duty is 0 and the strobe still fires.
- R5: When the incremented accumulator is greater than +65536, the accumulator is reloaded with -65536. No strobe is issued on that tick, and `dutyOut` keeps its previous value (65535 with the defaults, on tick 13108).
- R6: After a wrap, the ramp continues from -65536, so the next tick publishes 65526.
- R7: `periodOut` always equals 65536.
- R8: `countEnable` is high from the first rising edge after reset release. It is therefore high before, and whenever, `dutyStrobe` is high.
- R9: While `runEn` is low, the divider and the accumulator hold their state, no strobe is issued and `dutyOut` does not change. Counting resumes where it stopped.
- R10: Between strobes, `dutyOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Advances the divider and ramp when high; freezes them when low |
| dutyOut | output | DUTY_W (32) | Compare value for the PWM channel |
| dutyStrobe | output | 1 | One-cycle pulse marking a new `dutyOut` |
| periodOut | output | DUTY_W (32) | Fixed period value for the PWM counter |
| countEnable | output | 1 | Counter enable for the PWM counter |

## Verification
A new duty value and its strobe are due on the same rising edge that completes the N-th run-enabled interval of TICK_CYCLES cycles. The divider feeds the registered duty stage directly, so no further cycle of delay is added. The bench keeps its own count of run-enabled edges since reset release. For each tick index it waits until that count reaches index times TICK_CYCLES and samples on the following falling edge. It checks that the strobe is low again one cycle later, and it checks that the wrap tick leaves the strobe low while the duty value holds. `countEnable` is due one edge after reset release. `periodOut` is checked combinationally at any sample point.

// File: rtl/breath_pkg.sv
package breath_pkg;

  // Strobes passed from the sequencing control to the ramp datapath.
  typedef struct packed {
    logic advance;  // one tick of the update divider
    logic armed;    // the downstream counter may run
  } ctrlStrobes_t;

endpackage

// File: rtl/breath_ctrl.sv
module breath_ctrl
  import breath_pkg::*;
#(
  parameter int TICK_CYCLES = 7500
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         runEn,
  output ctrlStrobes_t ctrl
);

  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             armedQ;
  logic             tickNow;

  // Down-counter: a tick happens on the edge where it wraps from zero.
  assign tickNow = runEn && (tickCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= RELOAD;
    end else if (runEn) begin
      if (tickCnt == '0) begin
        tickCnt <= RELOAD;
      end else begin
        tickCnt <= tickCnt - 1'b1;
      end
    end
  end

  // The enable flag rises one edge after reset, earlier than any possible tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else begin
      armedQ <= 1'b1;
    end
  end

  assign ctrl.advance = tickNow;
  assign ctrl.armed   = armedQ;

endmodule

// File: rtl/breath_datapath.sv
module breath_datapath
  import breath_pkg::*;
#(
  parameter int ACC_W   = 20,
  parameter int DUTY_W  = 32,
  parameter int STEP    = 10,
  parameter int START   = -65535,
  parameter int WRAP_HI = 65536,
  parameter int WRAP_LO = -65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  output logic [DUTY_W-1:0] dutyOut,
  output logic              dutyStrobe
);

  localparam logic signed [ACC_W-1:0] STEP_V  = ACC_W'(STEP);
  localparam logic signed [ACC_W-1:0] START_V = ACC_W'(START);
  localparam logic signed [ACC_W-1:0] HI_V    = ACC_W'(WRAP_HI);
  localparam logic signed [ACC_W-1:0] LO_V    = ACC_W'(WRAP_LO);

  logic signed [ACC_W-1:0] phaseAcc;
  logic signed [ACC_W-1:0] phaseSum;
  logic signed [ACC_W-1:0] phaseMag;
  logic                    wrapHit;

  always_comb begin
    phaseSum = phaseAcc + STEP_V;
    wrapHit  = (phaseSum > HI_V);
    // Magnitude of the stepped value; zero maps to zero.
    if (phaseSum > $signed({ACC_W{1'b0}})) begin
      phaseMag = phaseSum;
    end else begin
      phaseMag = -phaseSum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= START_V;
    end else if (ctrl.advance) begin
      phaseAcc <= wrapHit ? LO_V : phaseSum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyOut    <= '0;
      dutyStrobe <= 1'b0;
    end else begin
      dutyStrobe <= ctrl.advance && !wrapHit;
      if (ctrl.advance && !wrapHit) begin
        dutyOut <= DUTY_W'($unsigned(phaseMag));
      end
    end
  end

endmodule

// File: rtl/breath_duty_seq.sv
module breath_duty_seq
  import breath_pkg::*;
#(
  parameter int TICK_CYCLES = 7500,
  parameter int ACC_W       = 20,
  parameter int DUTY_W      = 32,
  parameter int STEP        = 10,
  parameter int START       = -65535,
  parameter int WRAP_HI     = 65536,
  parameter int WRAP_LO     = -65536,
  parameter int PERIOD      = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  output logic [DUTY_W-1:0] dutyOut,
  output logic              dutyStrobe,
  output logic [DUTY_W-1:0] periodOut,
  output logic              countEnable
);

  ctrlStrobes_t ctrl;

  breath_ctrl #(
    .TICK_CYCLES(TICK_CYCLES)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .runEn(runEn),
    .ctrl (ctrl)
  );

  breath_datapath #(
    .ACC_W  (ACC_W),
    .DUTY_W (DUTY_W),
    .STEP   (STEP),
    .START  (START),
    .WRAP_HI(WRAP_HI),
    .WRAP_LO(WRAP_LO)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .dutyOut   (dutyOut),
    .dutyStrobe(dutyStrobe)
  );

  assign periodOut   = DUTY_W'(PERIOD);
  assign countEnable = ctrl.armed;

endmodule

// File: rtl/breath_duty_seq_chk.sv
module breath_duty_seq_chk #(
  parameter int TICK_CYCLES = 7500,
  parameter int DUTY_W      = 32,
  parameter int WRAP_HI     = 65536
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic [DUTY_W-1:0] dutyOut,
  input logic              dutyStrobe,
  input logic              countEnable
);

  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (TICK_CYCLES > 1 && dutyStrobe) |=> !dutyStrobe);

  p_duty_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    dutyStrobe |-> (dutyOut <= DUTY_W'(WRAP_HI)));

  p_enable_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    dutyStrobe |-> countEnable);

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!dutyStrobe && $stable(dutyOut)));

  p_duty_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dutyStrobe |-> $stable(dutyOut));

endmodule

bind breath_duty_seq breath_duty_seq_chk #(
  .TICK_CYCLES(TICK_CYCLES),
  .DUTY_W     (DUTY_W),
  .WRAP_HI    (WRAP_HI)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .runEn      (runEn),
  .dutyOut    (dutyOut),
  .dutyStrobe (dutyStrobe),
  .countEnable(countEnable)
);

// File: tb/breath_duty_seq_tb.sv
module breath_duty_seq_tb;

  localparam int TICK = 3;
  localparam int NTAB = 9;
  // tick index, expected strobe, expected duty
  localparam int TAB_TICK [NTAB] = '{1, 2, 6553, 6554, 6555, 13107, 13108, 13109, 13110};
  localparam bit TAB_STB  [NTAB] = '{1, 1, 1, 1, 1, 1, 0, 1, 1};
  localparam int TAB_DUTY [NTAB] = '{65525, 65515, 5, 5, 15, 65535, 65535, 65526, 65516};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b1;
  logic [31:0] dutyOut, periodOut, zDuty, zPeriod;
  logic        dutyStrobe, countEnable, zStrobe, zEnable;
  int          checks = 0;
  int          errors = 0;
  int          edgeCnt = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else if (runEn) edgeCnt <= edgeCnt + 1;
  end

  breath_duty_seq #(.TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .dutyOut(dutyOut),
    .dutyStrobe(dutyStrobe), .periodOut(periodOut), .countEnable(countEnable)
  );

  breath_duty_seq #(.TICK_CYCLES(2), .START(-20)) u_zero (
    .clk(clk), .rstN(rstN), .runEn(runEn), .dutyOut(zDuty),
    .dutyStrobe(zStrobe), .periodOut(zPeriod), .countEnable(zEnable)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int target);
    while (edgeCnt < target) @(negedge clk);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state, R7 period
    repeat (3) @(negedge clk);
    check(dutyOut == 0, "R1 duty in reset", dutyOut, 0);
    check(dutyStrobe == 0, "R1 strobe in reset", dutyStrobe, 0);
    check(countEnable == 0, "R1 enable in reset", countEnable, 0);
    check(periodOut == 32'd65536, "R7 period", periodOut, 65536);
    rstN = 1'b1;
    @(negedge clk);
    check(countEnable == 1, "R8 enable after first edge", countEnable, 1);
    check(dutyStrobe == 0, "R8 no strobe yet", dutyStrobe, 0);

    // Vector table: R2 R3 R5 R6 R10
    for (int i = 0; i < NTAB; i++) begin
      waitEdges(TAB_TICK[i] * TICK - 1);
      check(dutyStrobe == 0, "R10 no strobe before tick", dutyStrobe, 0);
      waitEdges(TAB_TICK[i] * TICK);
      check(dutyStrobe == TAB_STB[i], TAB_STB[i] ? "R2 strobe on tick" : "R5 no strobe on wrap",
            dutyStrobe, TAB_STB[i]);
      check(dutyOut == TAB_DUTY[i], i >= 7 ? "R6 duty after wrap" : (i == 6 ? "R5 duty held" : "R3 duty value"),
            dutyOut, TAB_DUTY[i]);
      @(negedge clk);
      check(dutyStrobe == 0, "R2 strobe one cycle", dutyStrobe, 0);
      check(dutyOut == TAB_DUTY[i], "R10 duty holds", dutyOut, TAB_DUTY[i]);
    end
    check(periodOut == 32'd65536, "R7 period running", periodOut, 65536);

    // R9 freeze
    runEn = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check(dutyStrobe == 0 && dutyOut == 65516, "R9 frozen", dutyOut, 65516);
    end
    runEn = 1'b1;
    waitEdges(13111 * TICK - 1);
    check(dutyStrobe == 0, "R9 no early strobe", dutyStrobe, 0);
    waitEdges(13111 * TICK);
    check(dutyStrobe == 1 && dutyOut == 65506, "R9 resume", dutyOut, 65506);

    // Reset mid-run, R1 restart and R4 zero magnitude
    rstN = 1'b0;
    @(negedge clk);
    check(dutyOut == 0 && countEnable == 0, "R1 reset mid-run", dutyOut, 0);
    rstN = 1'b1;
    waitEdges(2);
    check(zStrobe == 1 && zDuty == 10, "R3 zero-inst first tick", zDuty, 10);
    waitEdges(3);
    check(dutyStrobe == 1 && dutyOut == 65525, "R1 restart from start", dutyOut, 65525);
    waitEdges(4);
    check(zStrobe == 1, "R4 strobe at zero", zStrobe, 1);
    check(zDuty == 0, "R4 duty zero", zDuty, 0);
    waitEdges(6);
    check(zStrobe == 1 && zDuty == 10, "R4 past zero", zDuty, 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule